// File: doc/BRIEF.md
# Down-Counting Reload Timer Channel

This block is a single 32-bit timer channel. Software loads a reload value and a starting count through a small word-addressed register port. While an external start input is high, a power-of-four prescaler divides the clock. On each prescaled tick the counter steps down by one. When a tick arrives with the counter at zero, the counter takes the reload value and a sticky underflow flag is set.

An interrupt line is driven from that flag, gated by an enable bit in the control word. Software acknowledges the interrupt by writing the control word with the flag bit at 0. The prescaler phase restarts whenever the channel is stopped or the divide ratio changes. The first tick after either event therefore always comes a full period later.

Top module: `dtmr_channel`

## Requirements
- R1: After reset the reload and counter registers both read 0xFFFFFFFF, the control word reads 0, the interrupt is low, and the counter does not move while start is low.
- R2: Register words are selected by byte address bits [3:2]: 0 = reload value, 1 = counter, 2 = control, 3 = capture slot. The capture slot reads 0 and ignores writes. An access with address bits [1:0] not zero, or with any address bit above bit 3 set, is ignored.
- R3: Control bits [2:0] select the divide ratio. Values 0 to 4 divide by 4, 16, 64, 256 and 1024. With start high from a stopped state, the first decrement comes after exactly one full ratio of clock edges, and later decrements follow at that ratio.
- R4: Control select values 5, 6 and 7 produce no ticks, and the counter holds.
- R5: A tick with the counter at 0 loads the reload value into the counter and sets the underflow flag on the same clock edge.
- R6: The interrupt output is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R7: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag as it was, so a write can never set it.
- R8: A control read returns the select field in bits [2:0], the enable in bit 5 and the live underflow flag in bit 8. Every other bit reads 0, whatever was written, including the capture bits [7:6], bit 9 and bits [15:10].
- R9: While start is low the counter keeps its value, and counting resumes from that value when start returns high.
- R10: The prescaler phase resets when start is low and when a control write changes the select field. The first tick afterwards comes one full ratio later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Run enable from the unit-level start register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Underflow interrupt request |

## Verification
A register write takes effect on the clock edge that closes the strobe cycle. A read is combinational, so the bench samples it one time unit after the falling edge that sets the address. A counter decrement lands on the Nth rising edge after start rises, where N is the divide ratio, because the prescaler count and the counter are one register apart. The bench therefore steps whole falling-edge counts and checks the value one edge before and exactly at each expected tick. An underflow changes the counter, the flag and the interrupt on the same edge, and all three are checked together after that edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    // Control word field positions (decoded by software, so fixed)
    localparam int CTL_SEL_LSB = 0;
    localparam int CTL_IE_BIT  = 5;
    localparam int CTL_UF_BIT  = 8;
    localparam int CTL_W       = 16;

    typedef enum logic [1:0] {
        WO_RELOAD = 2'd0,
        WO_COUNT  = 2'd1,
        WO_CTRL   = 2'd2,
        WO_CAPT   = 2'd3
    } word_off_e;

    typedef struct packed {
        logic [2:0] sel;
        logic       ie;
    } ctl_t;

    typedef struct packed {
        logic ld_reload;
        logic ld_count;
        logic ld_ctl;
    } wr_strobe_t;

    function automatic ctl_t ctl_from_word(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.sel = w[CTL_SEL_LSB +: 3];
        c.ie  = w[CTL_IE_BIT];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_to_word(input ctl_t c, input logic flag);
        logic [CTL_W-1:0] w;
        w = '0;
        w[CTL_SEL_LSB +: 3] = c.sel;
        w[CTL_IE_BIT]       = c.ie;
        w[CTL_UF_BIT]       = flag;
        return w;
    endfunction

endpackage

// File: rtl/dtmr_regif.sv
module dtmr_regif
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] reload_q,
    input  logic [DATA_W-1:0] count_q,
    input  logic [CTL_W-1:0]  ctl_word,
    output wr_strobe_t        strobe,
    output logic [DATA_W-1:0] rdata
);
    logic      hit;
    word_off_e word;

    assign hit  = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
    assign word = word_off_e'(bus_addr[3:2]);

    always_comb begin
        strobe = '0;
        if (bus_wr && hit) begin
            case (word)
                WO_RELOAD: strobe.ld_reload = 1'b1;
                WO_COUNT:  strobe.ld_count  = 1'b1;
                WO_CTRL:   strobe.ld_ctl    = 1'b1;
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (word)
                WO_RELOAD: rdata = reload_q;
                WO_COUNT:  rdata = count_q;
                WO_CTRL:   rdata = DATA_W'(ctl_word);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
    import dtmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld_ctl,
    input  ctl_t wr_fields,
    input  logic wr_uf,
    input  logic uf_evt,
    output ctl_t ctl_q,
    output logic flag_q,
    output logic sel_chg,
    output logic irq_o
);
    assign sel_chg = ld_ctl && (wr_fields.sel != ctl_q.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ld_ctl) begin
            ctl_q <= wr_fields;
        end
    end

    // A fresh underflow outranks a same-cycle clear so no event is lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (uf_evt) begin
            flag_q <= 1'b1;
        end else if (ld_ctl && !wr_uf) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_o = flag_q & ctl_q.ie;
endmodule

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
    parameter int PS_STAGES = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [2:0] sel,
    input  logic       sel_chg,
    output logic       tick
);
    localparam int PW = 2 * PS_STAGES;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;
    logic          sel_ok;

    assign sel_ok = int'(sel) < PS_STAGES;

    // Ratio 4^(sel+1): one pair of mask bits per stage
    always_comb begin
        mask = '0;
        for (int i = 0; i < PS_STAGES; i++) begin
            mask[2*i +: 2] = (int'(sel) >= i) ? 2'b11 : 2'b00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !start_i || sel_chg) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = start_i && sel_ok && ((pre_q & mask) == mask);
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_reload,
    input  logic              ld_count,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] count_q,
    output logic              uf_evt
);
    logic at_zero;

    assign at_zero = (count_q == '0);
    assign uf_evt  = tick && !ld_count && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '1;
        end else if (ld_reload) begin
            reload_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '1;
        end else if (ld_count) begin
            count_q <= wdata;
        end else if (tick) begin
            count_q <= at_zero ? reload_q : count_q - 1'b1;
        end
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int PS_STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    wr_strobe_t        strobe;
    ctl_t              ctl_q;
    ctl_t              wr_fields;
    logic              flag_q;
    logic              sel_chg;
    logic              ps_tick;
    logic              uf_evt;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic [CTL_W-1:0]  ctl_word;

    assign wr_fields = ctl_from_word(bus_wdata[CTL_W-1:0]);
    assign ctl_word  = ctl_to_word(ctl_q, flag_q);

    dtmr_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .reload_q (reload_q),
        .count_q  (count_q),
        .ctl_word (ctl_word),
        .strobe   (strobe),
        .rdata    (bus_rdata)
    );

    dtmr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ld_ctl    (strobe.ld_ctl),
        .wr_fields (wr_fields),
        .wr_uf     (bus_wdata[CTL_UF_BIT]),
        .uf_evt    (uf_evt),
        .ctl_q     (ctl_q),
        .flag_q    (flag_q),
        .sel_chg   (sel_chg),
        .irq_o     (irq_o)
    );

    dtmr_prescaler #(.PS_STAGES(PS_STAGES)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .sel     (ctl_q.sel),
        .sel_chg (sel_chg),
        .tick    (ps_tick)
    );

    dtmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ld_reload (strobe.ld_reload),
        .ld_count  (strobe.ld_count),
        .wdata     (bus_wdata),
        .tick      (ps_tick),
        .reload_q  (reload_q),
        .count_q   (count_q),
        .uf_evt    (uf_evt)
    );
endmodule

// File: rtl/dtmr_channel_chk.sv
module dtmr_channel_chk #(
    parameter int DATA_W    = 32,
    parameter int PS_STAGES = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              irq_o,
    input logic              tick,
    input logic              ld_count,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] reload,
    input logic              flag,
    input logic              ie,
    input logic [2:0]        sel
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '1 && reload == '1 && !flag && !irq_o));

    // R4
    bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(sel) >= PS_STAGES) |-> !tick);

    // R5
    uf_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_count && count == '0) |=> (count == $past(reload) && flag));

    // R7
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick && count == '0));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq_o);

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !ld_count) |=> $stable(count));

    // R9
    no_tick_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |-> !tick);
endmodule

bind dtmr_channel dtmr_channel_chk #(.DATA_W(DATA_W), .PS_STAGES(PS_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .irq_o    (irq_o),
    .tick     (ps_tick),
    .ld_count (strobe.ld_count),
    .count    (count_q),
    .reload   (reload_q),
    .flag     (flag_q),
    .ie       (ctl_q.ie),
    .sel      (ctl_q.sel)
);

// File: tb/dtmr_channel_test.sv
`timescale 1ns/1ps
module dtmr_channel_test;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_RLD = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_CAP = 4'hC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dtmr_channel uut (
        .clk(clk), .rst(rst), .start_i(start_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [2:0] sel, input logic [DW-1:0] rld, input logic [DW-1:0] cnt);
        start_i = 1'b0;
        @(negedge clk);
        wr(A_CTL, {29'd0, sel});
        wr(A_RLD, rld);
        wr(A_CNT, cnt);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        rd(A_RLD, d); chk("R1 reload after reset", d, 32'hFFFF_FFFF);
        rd(A_CNT, d); chk("R1 counter after reset", d, 32'hFFFF_FFFF);
        rd(A_CTL, d); chk("R1 control after reset", d, 32'h0);
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        run(20);
        rd(A_CNT, d); chk("R1 stopped after reset", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_div4();
        logic [DW-1:0] d;
        setup(3'd0, 32'd500, 32'd100);
        start_i = 1'b1;
        run(3);  rd(A_CNT, d); chk("R3 div4 before first tick", d, 32'd100);
        run(1);  rd(A_CNT, d); chk("R3 div4 first tick", d, 32'd99);
        run(36); rd(A_CNT, d); chk("R3 div4 after 40 edges", d, 32'd90);
        start_i = 1'b0;
        run(10); rd(A_CNT, d); chk("R9 hold while stopped", d, 32'd90);
        start_i = 1'b1;
        run(3);  rd(A_CNT, d); chk("R10 restart full period pending", d, 32'd90);
        run(1);  rd(A_CNT, d); chk("R9 resume from held value", d, 32'd89);
        start_i = 1'b0;
    endtask

    task automatic t_ratios();
        logic [DW-1:0] d;
        for (int s = 1; s <= 4; s++) begin
            int div;
            div = 4 << (2 * s);
            setup(3'(s), 32'd0, 32'd10);
            start_i = 1'b1;
            run(div - 1); rd(A_CNT, d); chk($sformatf("R3 sel%0d one edge early", s), d, 32'd10);
            run(1);       rd(A_CNT, d); chk($sformatf("R3 sel%0d first tick", s), d, 32'd9);
            if (s == 1) begin
                run(47); rd(A_CNT, d); chk("R3 sel1 steady ratio early", d, 32'd7);
                run(1);  rd(A_CNT, d); chk("R3 sel1 steady ratio", d, 32'd6);
            end
            start_i = 1'b0;
        end
    endtask

    task automatic t_sel_change();
        logic [DW-1:0] d;
        setup(3'd0, 32'd0, 32'd20);
        start_i = 1'b1;
        run(2);
        wr(A_CTL, 32'h1);
        run(15); rd(A_CNT, d); chk("R10 sel change resets phase", d, 32'd20);
        run(1);  rd(A_CNT, d); chk("R10 first tick after sel change", d, 32'd19);
        start_i = 1'b0;
    endtask

    task automatic t_reserved();
        logic [DW-1:0] d;
        for (int s = 5; s <= 7; s++) begin
            setup(3'(s), 32'd0, 32'd7);
            start_i = 1'b1;
            run(1100);
            rd(A_CNT, d); chk($sformatf("R4 sel%0d no counting", s), d, 32'd7);
            start_i = 1'b0;
        end
    endtask

    task automatic t_underflow();
        logic [DW-1:0] d;
        setup(3'd0, 32'd3, 32'd1);
        start_i = 1'b1;
        run(4); rd(A_CNT, d); chk("R5 reached zero", d, 32'd0);
        rd(A_CTL, d); chk("R5 no flag at zero", d, 32'h0);
        run(4); start_i = 1'b0;
        rd(A_CNT, d); chk("R5 reload on underflow", d, 32'd3);
        rd(A_CTL, d); chk("R5 flag set on underflow", d, 32'h100);
        chk("R6 irq low with enable 0", {31'd0, irq_o}, 32'd0);
        wr(A_CTL, 32'h120);
        chk("R6 irq high with flag and enable", {31'd0, irq_o}, 32'd1);
        rd(A_CTL, d); chk("R7 write bit8=1 keeps flag", d, 32'h120);
        wr(A_CTL, 32'h20);
        rd(A_CTL, d); chk("R7 write bit8=0 clears flag", d, 32'h20);
        chk("R6 irq low after clear", {31'd0, irq_o}, 32'd0);
        wr(A_CTL, 32'h120);
        rd(A_CTL, d); chk("R7 write cannot set flag", d, 32'h20);
        chk("R7 irq stays low", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_ctl_read();
        logic [DW-1:0] d;
        start_i = 1'b0;
        wr(A_CTL, 32'hFFFF_FEFF);
        rd(A_CTL, d); chk("R8 only stored fields read back", d, 32'h27);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_capture();
        logic [DW-1:0] d;
        wr(A_RLD, 32'hCAFE_0001);
        wr(A_CAP, 32'h1234_5678);
        rd(A_CAP, d); chk("R2 capture slot reads 0", d, 32'h0);
        rd(A_RLD, d); chk("R2 reload register write/read", d, 32'hCAFE_0001);
        wr(4'h5, 32'h0000_0055);
        rd(A_CNT, d); chk("R2 misaligned write ignored", d != 32'h55 ? 32'd1 : 32'd0, 32'd1);
        wr(A_CNT, 32'hABCD_0000);
        rd(A_CNT, d); chk("R2 counter write/read", d, 32'hABCD_0000);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_div4();
        t_ratios();
        t_sel_change();
        t_reserved();
        t_underflow();
        t_ctl_read();
        t_capture();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule